// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the target-side serial port of a flash memory model. It watches an active-low select line, a serial clock and a serial data input, all already synchronous to the system clock. It samples them on the system clock and finds the edges of the serial clock itself. Each transaction begins when the select line falls. The block shifts in an opcode, then a 24-bit address, then a number of dummy bytes that depends on the opcode. After that it streams bytes from a byte-wide data source out on the serial output, most significant bit first.

Two read opcodes are recognised. 0xE8 is the legacy read and takes four dummy bytes. 0x0B is the fast read and takes one dummy byte. Any other opcode raises an error flag, and the port stays silent until the select line rises. Input bits are taken on rising serial-clock edges and output bits are launched on falling ones. Falling edges that arrive before the data phase are ignored, so the port works with the clock idling low or high. The data source receives one request pulse per output byte, well before the byte is needed. Address sequencing in the source is outside this block.

Top module: `sfe_cmd_front`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sdo_en`, `bad_cmd`, `cmd_valid`, `rd_req` and `addr_valid` are all 0.
- R2: While `cs_n` is high, `sdo_en` is 0 and activity on `sck` and `sdi` produces no `cmd_valid`, no `rd_req` and no `bad_cmd`. A transaction starts only on a high-to-low change of `cs_n`.
- R3: The first 8 bits after select, taken on rising `sck` edges MSB first, form the opcode. For 0xE8 or 0x0B, `cmd_valid` pulses for exactly one cycle and `cmd_code` shows the opcode.
- R4: The next 24 rising-edge bits form `addr`, MSB first. `addr_valid` rises after the 24th bit, and `addr` then stays constant until the next transaction.
- R5: Opcode 0xE8 is followed by 4 dummy bytes and 0x0B by 1 dummy byte. `sdo_en` is 0 through the dummy bytes and becomes 1 after the rising edge of the last dummy bit.
- R6: In the data phase, `sdo` changes only after a falling `sck` edge. Each output byte is sent MSB first, so bit 7 of the byte appears after the first falling edge that follows the byte's load.
- R7: `rd_req` is a one-cycle pulse, issued at the rising edge of the first bit of the last dummy byte and of every data byte. The next output byte is taken from `rd_data` at the rising edge of the last bit of the preceding byte. Reading N whole bytes therefore yields N+1 requests.
- R8: Any other opcode sets `bad_cmd`. While it is set, `cmd_valid`, `rd_req` and `sdo_en` stay 0.
- R9: A rise of `cs_n` at any point, including mid-byte, ends the transaction. `sdo_en` and `bad_cmd` are 0 from the second cycle on, and the next fall of `cs_n` starts a fresh opcode.
- R10: Transactions behave the same whether `sck` idles low or high when `cs_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| rd_data | input | 8 | Byte from data source, valid from the cycle after `rd_req` |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_en | output | 1 | Output enable for the tri-state driver |
| cmd_valid | output | 1 | One-cycle pulse on a recognised opcode |
| cmd_code | output | 8 | Last recognised opcode |
| addr | output | 24 | Captured address |
| addr_valid | output | 1 | Address complete for this transaction |
| rd_req | output | 1 | One-cycle request for the next output byte |
| bad_cmd | output | 1 | Unrecognised opcode seen, cleared by select rising |

## Verification
The checker examines every cycle for the pulse width of `cmd_valid` and `rd_req`, for a silent output with select high, for silence after an error, and for a stable address once it is valid. It also checks that `sdo` moves only after a falling serial-clock edge. Dummy-byte counts, MSB-first ordering of opcode, address and data, the number of requests per read, and behaviour with either idle clock level can only be shown by the bench's transactions. The same holds for ending a read mid-byte.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OPC_RD_LEGACY = 8'hE8;
    localparam logic [BYTE_W-1:0] OPC_RD_FAST   = 8'h0B;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DROP
    } sfe_state_e;

    typedef struct packed {
        logic rise;   // serial clock rising, select low
        logic fall;   // serial clock falling, select low
        logic start;  // select just went low
    } sfe_evt_t;

    function automatic logic is_read_op(input logic [BYTE_W-1:0] op);
        return (op == OPC_RD_LEGACY) || (op == OPC_RD_FAST);
    endfunction

endpackage

// File: rtl/sfe_edge.sv
module sfe_edge #(
    parameter int unsigned N = 2,
    parameter logic [N-1:0] RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= RST_LVL;
        else     lvl_q <= lvl;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] =  lvl[g] & ~lvl_q[g];
        assign fall[g] = ~lvl[g] &  lvl_q[g];
    end
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
    import sfe_pkg::*;
#(
    parameter int unsigned ADDR_BYTES   = 3,
    parameter int unsigned LEGACY_DUMMY = 4,
    parameter int unsigned FAST_DUMMY   = 1,
    localparam int unsigned ADDR_W = ADDR_BYTES * BYTE_W,
    localparam int unsigned ABC_W  = $clog2(ADDR_BYTES + 1),
    localparam int unsigned MAXD   = (LEGACY_DUMMY > FAST_DUMMY) ? LEGACY_DUMMY : FAST_DUMMY,
    localparam int unsigned DUM_W  = $clog2(MAXD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sdi,
    input  sfe_evt_t          evt,
    output sfe_state_e        state,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_code,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic              rd_req,
    output logic              load,
    output logic              bad_cmd
);
    logic [BIT_W-1:0]  bit_cnt;
    logic [ABC_W-1:0]  byte_cnt;
    logic [DUM_W-1:0]  dummy_left;
    logic [BYTE_W-1:0] opc_sr;
    logic [BYTE_W-1:0] opc_next;
    logic              last_bit;
    logic              first_bit;

    assign opc_next  = {opc_sr[BYTE_W-2:0], sdi};
    assign last_bit  = (bit_cnt == BIT_W'(BYTE_W - 1));
    assign first_bit = (bit_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            byte_cnt   <= '0;
            dummy_left <= '0;
            opc_sr     <= '0;
            cmd_valid  <= 1'b0;
            cmd_code   <= '0;
            addr       <= '0;
            addr_valid <= 1'b0;
            rd_req     <= 1'b0;
            load       <= 1'b0;
            bad_cmd    <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            rd_req    <= 1'b0;
            load      <= 1'b0;
            if (cs_n) begin
                state   <= ST_IDLE;
                bad_cmd <= 1'b0;
            end else if (evt.start) begin
                state      <= ST_OPC;
                bit_cnt    <= '0;
                byte_cnt   <= '0;
                addr_valid <= 1'b0;
            end else if (evt.rise) begin
                unique case (state)
                    ST_OPC: begin
                        opc_sr  <= opc_next;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            if (is_read_op(opc_next)) begin
                                cmd_valid <= 1'b1;
                                cmd_code  <= opc_next;
                                state     <= ST_ADDR;
                                dummy_left <= (opc_next == OPC_RD_LEGACY)
                                            ? DUM_W'(LEGACY_DUMMY - 1)
                                            : DUM_W'(FAST_DUMMY - 1);
                            end else begin
                                bad_cmd <= 1'b1;
                                state   <= ST_DROP;
                            end
                        end
                    end
                    ST_ADDR: begin
                        addr    <= {addr[ADDR_W-2:0], sdi};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            if (byte_cnt == ABC_W'(ADDR_BYTES - 1)) begin
                                addr_valid <= 1'b1;
                                state      <= ST_DUMMY;
                            end else begin
                                byte_cnt <= byte_cnt + 1'b1;
                            end
                        end
                    end
                    ST_DUMMY: begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (first_bit && dummy_left == '0) rd_req <= 1'b1;
                        if (last_bit) begin
                            if (dummy_left == '0) begin
                                load  <= 1'b1;
                                state <= ST_DATA;
                            end else begin
                                dummy_left <= dummy_left - 1'b1;
                            end
                        end
                    end
                    ST_DATA: begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (first_bit) rd_req <= 1'b1;
                        if (last_bit)  load   <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfe_shift_out.sv
module sfe_shift_out
    import sfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              load,
    input  logic              fall,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sdo_bit
);
    logic [BYTE_W-1:0] out_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sr  <= '0;
            sdo_bit <= 1'b0;
        end else if (load) begin
            out_sr <= rd_data;
        end else if (active && fall) begin
            sdo_bit <= out_sr[BYTE_W-1];
            out_sr  <= {out_sr[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sfe_cmd_front.sv
module sfe_cmd_front
    import sfe_pkg::*;
#(
    parameter int unsigned ADDR_BYTES   = 3,
    parameter int unsigned LEGACY_DUMMY = 4,
    parameter int unsigned FAST_DUMMY   = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sck,
    input  logic                         cs_n,
    input  logic                         sdi,
    input  logic [7:0]                   rd_data,
    output logic                         sdo,
    output logic                         sdo_en,
    output logic                         cmd_valid,
    output logic [7:0]                   cmd_code,
    output logic [ADDR_BYTES*8-1:0]      addr,
    output logic                         addr_valid,
    output logic                         rd_req,
    output logic                         bad_cmd
);
    logic [1:0] lvl_rise, lvl_fall;
    sfe_evt_t   evt;
    sfe_state_e state;
    logic       load;
    logic       sdo_bit;

    sfe_edge #(.N(2), .RST_LVL(2'b10)) i_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({cs_n, sck}),
        .rise (lvl_rise),
        .fall (lvl_fall)
    );

    assign evt.rise  = lvl_rise[0] & ~cs_n;
    assign evt.fall  = lvl_fall[0] & ~cs_n;
    assign evt.start = lvl_fall[1];

    sfe_seq #(
        .ADDR_BYTES   (ADDR_BYTES),
        .LEGACY_DUMMY (LEGACY_DUMMY),
        .FAST_DUMMY   (FAST_DUMMY)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .evt        (evt),
        .state      (state),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .addr       (addr),
        .addr_valid (addr_valid),
        .rd_req     (rd_req),
        .load       (load),
        .bad_cmd    (bad_cmd)
    );

    sfe_shift_out i_out (
        .clk     (clk),
        .rst     (rst),
        .active  (state == ST_DATA),
        .load    (load),
        .fall    (evt.fall),
        .rd_data (rd_data),
        .sdo_bit (sdo_bit)
    );

    assign sdo_en = (state == ST_DATA);
    assign sdo    = sdo_en & sdo_bit;
endmodule

// File: rtl/sfe_cmd_front_chk.sv
module sfe_cmd_front_chk #(
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              sck,
    input logic              cs_n,
    input logic              sdo,
    input logic              sdo_en,
    input logic              cmd_valid,
    input logic              rd_req,
    input logic              bad_cmd,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !sdo_en && !bad_cmd && !cmd_valid && !rd_req && !addr_valid);

    assert_deselect_silent_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n && $past(cs_n) |-> !sdo_en && !cmd_valid && !rd_req);

    assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        addr_valid && $past(addr_valid) |-> $stable(addr));

    assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        sdo_en && $past(sdo_en) && (sdo != $past(sdo)) |-> !$past(sck) && $past(sck, 2));

    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    assert_error_silent_R8: assert property (@(posedge clk) disable iff (rst)
        bad_cmd |-> !sdo_en && !rd_req && !cmd_valid);

    assert_error_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        cs_n && $past(cs_n) |-> !bad_cmd);
endmodule

bind sfe_cmd_front sfe_cmd_front_chk #(.ADDR_W(ADDR_BYTES * 8)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .sck        (sck),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .cmd_valid  (cmd_valid),
    .rd_req     (rd_req),
    .bad_cmd    (bad_cmd),
    .addr_valid (addr_valid),
    .addr       (addr)
);

// File: tb/test_sfe_cmd_front.sv
`timescale 1ns/1ps
module test_sfe_cmd_front;
    localparam int HALF = 4;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        sdo, sdo_en, cmd_valid, addr_valid, rd_req, bad_cmd;
    logic [7:0]  cmd_code;
    logic [23:0] addr;

    int n_chk = 0;
    int n_fail = 0;
    int n_cmd = 0;
    int n_req = 0;
    int cycles = 0;
    bit idle_hi = 1'b0;

    always #10 clk = ~clk;

    sfe_cmd_front i_sfe_cmd_front (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi), .rd_data(rd_data),
        .sdo(sdo), .sdo_en(sdo_en), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .addr(addr), .addr_valid(addr_valid), .rd_req(rd_req), .bad_cmd(bad_cmd)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 29 + 7) ^ 8'hA5;
    endfunction

    // data source model: byte i answers request i
    always @(posedge clk) begin
        if (rd_req) begin
            rd_data <= pat(n_req);
            n_req   <= n_req + 1;
        end
        if (cmd_valid) n_cmd <= n_cmd + 1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sck = 1'b0;
            sdi = tx[i];
            wait_clk(HALF);
            rx[i] = sdo;
            sck = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic select(input bit hi);
        idle_hi = hi;
        sck = hi;
        wait_clk(3);
        cs_n = 1'b0;
        wait_clk(3);
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1;
        wait_clk(2);
        sck = idle_hi;
        wait_clk(3);
    endtask

    task automatic read_txn(input bit hi, input logic [7:0] op, input logic [23:0] a, input int nbytes);
        logic [7:0] rx;
        int cmd0, req0, nd;
        cmd0 = n_cmd;
        select(hi);
        req0 = n_req;
        xfer(op, rx);
        wait_clk(1);
        chk(n_cmd == cmd0 + 1, "R3 cmd_valid count", n_cmd, cmd0 + 1);
        chk(cmd_code == op, "R3 cmd_code", cmd_code, op);
        xfer(a[23:16], rx);
        xfer(a[15:8], rx);
        chk(addr_valid == 1'b0, "R4 addr_valid early", addr_valid, 0);
        xfer(a[7:0], rx);
        chk(addr == a, "R4 addr", addr, a);
        chk(addr_valid == 1'b1, "R4 addr_valid", addr_valid, 1);
        nd = (op == 8'hE8) ? 4 : 1;
        for (int d = 0; d < nd; d++) begin
            chk(sdo_en == 1'b0, "R5 sdo_en during dummy", sdo_en, 0);
            xfer(8'h00, rx);
        end
        wait_clk(1);
        chk(sdo_en == 1'b1, "R5 sdo_en after dummy", sdo_en, 1);
        for (int b = 0; b < nbytes; b++) begin
            xfer(8'h00, rx);
            chk(rx == pat(req0 + b), hi ? "R10 R6 data byte mode3" : "R6 data byte mode0", rx, pat(req0 + b));
        end
        deselect();
        chk(sdo_en == 1'b0, "R9 sdo_en after deselect", sdo_en, 0);
        chk(n_req - req0 == nbytes + 1, "R7 request count", n_req - req0, nbytes + 1);
    endtask

    initial begin
        logic [7:0] rx;
        int c0, r0;
        void'($urandom(32'h5EED_0042));
        wait_clk(4);
        chk(sdo_en == 0 && bad_cmd == 0 && rd_req == 0 && cmd_valid == 0, "R1 during reset",
            {sdo_en, bad_cmd, rd_req, cmd_valid}, 0);
        rst = 1'b0;
        wait_clk(1);
        chk(sdo_en == 0 && bad_cmd == 0 && addr_valid == 0, "R1 after reset",
            {sdo_en, bad_cmd, addr_valid}, 0);

        // R2: clocking with select high
        c0 = n_cmd; r0 = n_req;
        xfer(8'hE8, rx);
        xfer(8'h0B, rx);
        chk(n_cmd == c0 && n_req == r0 && sdo_en == 0 && bad_cmd == 0, "R2 deselected activity",
            {n_cmd - c0, n_req - r0, sdo_en, bad_cmd}, 0);
        sck = 1'b0;

        // directed reads, both clock idle levels
        read_txn(1'b0, 8'h0B, 24'h1A2B3C, 3);
        read_txn(1'b1, 8'hE8, 24'hFEDCBA, 2);
        read_txn(1'b1, 8'h0B, 24'h000001, 1);
        read_txn(1'b0, 8'hE8, 24'h800000, 4);

        // R8: unsupported opcode
        c0 = n_cmd; r0 = n_req;
        select(1'b0);
        xfer(8'h03, rx);
        wait_clk(1);
        chk(bad_cmd == 1'b1, "R8 bad_cmd set", bad_cmd, 1);
        xfer(8'h12, rx);
        xfer(8'h34, rx);
        xfer(8'h56, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        chk(sdo_en == 0 && n_cmd == c0 && n_req == r0, "R8 silent after bad opcode",
            {sdo_en, n_cmd - c0, n_req - r0}, 0);
        deselect();
        chk(bad_cmd == 1'b0, "R9 bad_cmd cleared", bad_cmd, 0);

        // R9: abort mid byte, then a fresh transaction decodes
        select(1'b0);
        xfer(8'h0B, rx);
        xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h10, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); sck = 1'b0; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
        end
        chk(sdo_en == 1'b1, "R9 data phase before abort", sdo_en, 1);
        deselect();
        chk(sdo_en == 1'b0, "R9 abort mid byte", sdo_en, 0);
        read_txn(1'b0, 8'h0B, 24'h0F0F0F, 2);

        // constrained random reads
        for (int t = 0; t < 8; t++) begin
            logic [23:0] a;
            bit hi;
            logic [7:0] op;
            a  = 24'($urandom);
            hi = 1'($urandom);
            op = ($urandom % 2) ? 8'hE8 : 8'h0B;
            read_txn(hi, op, a, 1 + int'($urandom % 4));
        end

        summary();
    end
endmodule